// File: doc/BRIEF.md
# Boundary-Scan Test State Controller

This block is the sequencing core of a boundary-scan test port. A sixteen-state machine runs on the test clock. At every rising edge it samples the mode-select line and moves to its next state. The state graph has two parallel branches of the same shape. One scans the instruction register and the other scans whichever data register is selected. Each branch steps through capture, shift, exit, pause and update states. The data-branch selection state is the only way into the instruction branch.

The controller does not hold any instruction or data register contents. Instead it gives the surrounding test logic a set of decoded controls. The capture, shift and reset indications come straight from the state register, for use by registers that act on the rising edge. The update strobes and the serial-output enable are registered on the falling edge, so serial data and parallel updates change half a test-clock cycle away from the sampling edge. An active-low asynchronous test reset forces the machine into its reset state at once. Its release is synchronised to the test clock over a parameterised number of stages.

Top module: `scan_tap_fsm`

## Requirements
- R1: While `trst_n` is low, `tap_state_o` reads 0 (test-logic-reset), `reset_o` is 1 and every other control output is 0.
- R2: The state code is: 0 reset, 1 run/idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. Every transition follows the standard scan graph on the `tms` level sampled at the rising `tck` edge.
- R3: Select-IR (9) is entered only from select-DR (2) with `tms` high.
- R4: Five consecutive rising edges with `tms` high reach state 0 from any state.
- R5: Either pause state holds while `tms` is low.
- R6: Exit1 and exit2 of either branch move to that branch's update state when `tms` is high.
- R7: Asserting `trst_n` low forces state 0 and clears the falling-edge outputs without waiting for a clock edge.
- R8: After `trst_n` rises, the first SYNC_STAGES rising edges (default 2) leave the state at 0, and the next edge follows `tms`.
- R9: `tdo_oe_o` is updated on the falling edge of `tck` and is 1 exactly in the half cycles that follow a falling edge seen in state 4 or 11.
- R10: `ir_update_o` / `dr_update_o` are updated on the falling edge and are 1 exactly in the half cycles that follow a falling edge seen in state 15 / 8.
- R11: `ir_capture_o`, `ir_shift_o`, `dr_capture_o`, `dr_shift_o` and `reset_o` are high exactly in states 10, 11, 3, 4 and 0 respectively, so at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tap_state_o | output | 4 | Current state code (see R2) |
| reset_o | output | 1 | In test-logic-reset |
| ir_capture_o | output | 1 | In capture-IR |
| ir_shift_o | output | 1 | In shift-IR |
| ir_update_o | output | 1 | Falling-edge update strobe, instruction branch |
| dr_capture_o | output | 1 | In capture-DR |
| dr_shift_o | output | 1 | In shift-DR |
| dr_update_o | output | 1 | Falling-edge update strobe, data branch |
| tdo_oe_o | output | 1 | Falling-edge serial output enable |

## Verification
The assertions take for granted that `tms` is stable across each rising edge of `tck`. They also assume the test reset is released well away from an edge, so that the synchronised reset covers the state register and the falling-edge stage together. The bench keeps to this. It changes `tms` only one time unit after a falling edge and moves `trst_n` only in the low half of the clock. The falling-edge assertions compare the registered outputs with the state at the next rising edge, so stimulus must never change the state between those two edges.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int TAP_STATE_W = 4;

  typedef enum logic [TAP_STATE_W-1:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tap_next_state.sv
module tap_next_state
  import scan_tap_pkg::*;
(
  input  tap_state_e cur_i,
  input  logic       tms_i,
  output tap_state_e nxt_o
);
  always_comb begin
    nxt_o = ST_RESET;
    unique case (cur_i)
      ST_RESET:  nxt_o = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt_o = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt_o = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt_o = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt_o = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt_o = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt_o = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt_o = tms_i ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt_o = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt_o = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt_o = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt_o = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt_o = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt_o = tms_i ? ST_SEL_DR : ST_IDLE;
      default:   nxt_o = ST_RESET;
    endcase
  end
endmodule

// File: rtl/tap_out_stage.sv
module tap_out_stage
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state_i,
  output logic       reset_o,
  output logic       ir_capture_o,
  output logic       ir_shift_o,
  output logic       dr_capture_o,
  output logic       dr_shift_o,
  output logic       ir_update_o,
  output logic       dr_update_o,
  output logic       tdo_oe_o
);
  logic oe_d, upd_ir_d, upd_dr_d;
  logic oe_q, upd_ir_q, upd_dr_q;

  // rising-edge consumers use the state decode directly
  always_comb begin
    reset_o      = (state_i == ST_RESET);
    ir_capture_o = (state_i == ST_CAP_IR);
    ir_shift_o   = (state_i == ST_SH_IR);
    dr_capture_o = (state_i == ST_CAP_DR);
    dr_shift_o   = (state_i == ST_SH_DR);
    oe_d         = (state_i == ST_SH_IR) || (state_i == ST_SH_DR);
    upd_ir_d     = (state_i == ST_UPD_IR);
    upd_dr_d     = (state_i == ST_UPD_DR);
  end

  // half-cycle offset for serial output and parallel update
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      oe_q     <= 1'b0;
      upd_ir_q <= 1'b0;
      upd_dr_q <= 1'b0;
    end else begin
      oe_q     <= oe_d;
      upd_ir_q <= upd_ir_d;
      upd_dr_q <= upd_dr_d;
    end
  end

  assign tdo_oe_o    = oe_q;
  assign ir_update_o = upd_ir_q;
  assign dr_update_o = upd_dr_q;
endmodule

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   tck,
  input  logic                   trst_n,
  input  logic                   tms,
  output logic [TAP_STATE_W-1:0] tap_state_o,
  output logic                   reset_o,
  output logic                   ir_capture_o,
  output logic                   ir_shift_o,
  output logic                   ir_update_o,
  output logic                   dr_capture_o,
  output logic                   dr_shift_o,
  output logic                   dr_update_o,
  output logic                   tdo_oe_o
);
  logic       rst_sync_n;
  tap_state_e state_q, state_d;

  tap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_sync_n)
  );

  tap_next_state u_nxt (
    .cur_i (state_q),
    .tms_i (tms),
    .nxt_o (state_d)
  );

  always_ff @(posedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_RESET;
    else             state_q <= state_d;
  end

  tap_out_stage u_out (
    .tck          (tck),
    .rst_n        (rst_sync_n),
    .state_i      (state_q),
    .reset_o      (reset_o),
    .ir_capture_o (ir_capture_o),
    .ir_shift_o   (ir_shift_o),
    .dr_capture_o (dr_capture_o),
    .dr_shift_o   (dr_shift_o),
    .ir_update_o  (ir_update_o),
    .dr_update_o  (dr_update_o),
    .tdo_oe_o     (tdo_oe_o)
  );

  assign tap_state_o = state_q;
endmodule

// File: rtl/scan_tap_fsm_chk.sv
module scan_tap_fsm_chk (
  input logic       tck,
  input logic       rst_n,
  input logic       tms,
  input logic [3:0] st,
  input logic       rst_flag,
  input logic       cap_ir,
  input logic       sh_ir,
  input logic       cap_dr,
  input logic       sh_dr,
  input logic       upd_ir,
  input logic       upd_dr,
  input logic       oe
);
  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)            ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R3
  a_r3_sel_ir_entry: assert property (@(posedge tck) disable iff (!rst_n)
    (st == 4'd9) |-> ($past(st) == 4'd2 && $past(tms)));

  // R4
  a_r4_five_ones: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q == 3'd5) |-> (st == 4'd0));

  // R5
  a_r5_pause_dr_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (st == 4'd6 && !tms) |=> (st == 4'd6));
  a_r5_pause_ir_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (st == 4'd13 && !tms) |=> (st == 4'd13));

  // R6
  a_r6_exit_dr_update: assert property (@(posedge tck) disable iff (!rst_n)
    ((st == 4'd5 || st == 4'd7) && tms) |=> (st == 4'd8));
  a_r6_exit_ir_update: assert property (@(posedge tck) disable iff (!rst_n)
    ((st == 4'd12 || st == 4'd14) && tms) |=> (st == 4'd15));

  // R9: falling-edge register seen at the following rising edge
  a_r9_oe_tracks_shift: assert property (@(posedge tck) disable iff (!rst_n)
    oe == (st == 4'd4 || st == 4'd11));

  // R10
  a_r10_update_strobes: assert property (@(posedge tck) disable iff (!rst_n)
    (upd_ir == (st == 4'd15)) && (upd_dr == (st == 4'd8)));

  // R11
  a_r11_onehot_decode: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({rst_flag, cap_ir, sh_ir, cap_dr, sh_dr}));
endmodule

bind scan_tap_fsm scan_tap_fsm_chk u_chk (
  .tck      (tck),
  .rst_n    (rst_sync_n),
  .tms      (tms),
  .st       (tap_state_o),
  .rst_flag (reset_o),
  .cap_ir   (ir_capture_o),
  .sh_ir    (ir_shift_o),
  .cap_dr   (dr_capture_o),
  .sh_dr    (dr_shift_o),
  .upd_ir   (ir_update_o),
  .upd_dr   (dr_update_o),
  .oe       (tdo_oe_o)
);

// File: tb/sim_scan_tap_fsm.sv
`timescale 1ns/1ps
module sim_scan_tap_fsm;
  logic       tck;
  logic       trst_n;
  logic       tms;
  logic [3:0] st;
  logic       rst_o, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr, oe;

  int n_chk;
  int n_fail;
  int model;

  scan_tap_fsm #(.SYNC_STAGES(2)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tap_state_o(st),
    .reset_o(rst_o), .ir_capture_o(cap_ir), .ir_shift_o(sh_ir),
    .ir_update_o(upd_ir), .dr_capture_o(cap_dr), .dr_shift_o(sh_dr),
    .dr_update_o(upd_dr), .tdo_oe_o(oe)
  );

  initial tck = 1'b0;
  always #4 tck = ~tck;

  function automatic int nxt(input int s, input logic t);
    case (s)
      0:  return t ? 0  : 1;
      1:  return t ? 2  : 1;
      2:  return t ? 9  : 3;
      3:  return t ? 5  : 4;
      4:  return t ? 5  : 4;
      5:  return t ? 8  : 6;
      6:  return t ? 7  : 6;
      7:  return t ? 8  : 4;
      8:  return t ? 2  : 1;
      9:  return t ? 0  : 10;
      10: return t ? 12 : 11;
      11: return t ? 12 : 11;
      12: return t ? 15 : 13;
      13: return t ? 14 : 13;
      14: return t ? 15 : 11;
      default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_decode();
    chk(int'(st) == model, "R2 state", int'(st), model);
    chk(rst_o == (model == 0), "R11 reset_o", int'(rst_o), int'(model == 0));
    chk(cap_ir == (model == 10), "R11 ir_capture", int'(cap_ir), int'(model == 10));
    chk(sh_ir == (model == 11), "R11 ir_shift", int'(sh_ir), int'(model == 11));
    chk(cap_dr == (model == 3), "R11 dr_capture", int'(cap_dr), int'(model == 3));
    chk(sh_dr == (model == 4), "R11 dr_shift", int'(sh_dr), int'(model == 4));
  endtask

  task automatic chk_falling(input int s);
    chk(oe == (s == 4 || s == 11), "R9 tdo_oe", int'(oe), int'(s == 4 || s == 11));
    chk(upd_ir == (s == 15), "R10 ir_update", int'(upd_ir), int'(s == 15));
    chk(upd_dr == (s == 8), "R10 dr_update", int'(upd_dr), int'(s == 8));
  endtask

  // entered and left one time unit after a falling edge
  task automatic step(input logic t);
    int prev;
    tms = t;
    prev = model;
    @(posedge tck);
    model = nxt(model, t);
    #1;
    chk_decode();
    chk_falling(prev);
    @(negedge tck);
    #1;
    chk_falling(model);
  endtask

  task automatic goto_state(input int s);
    logic [7:0] seq;
    int len;
    for (int i = 0; i < 5; i++) step(1'b1);
    case (s)
      1:  begin seq = 8'b0;       len = 1; end
      2:  begin seq = 8'b10;      len = 2; end
      3:  begin seq = 8'b010;     len = 3; end
      4:  begin seq = 8'b0010;    len = 4; end
      5:  begin seq = 8'b1010;    len = 4; end
      6:  begin seq = 8'b01010;   len = 5; end
      7:  begin seq = 8'b101010;  len = 6; end
      8:  begin seq = 8'b11010;   len = 5; end
      9:  begin seq = 8'b110;     len = 3; end
      10: begin seq = 8'b0110;    len = 4; end
      11: begin seq = 8'b00110;   len = 5; end
      12: begin seq = 8'b10110;   len = 5; end
      13: begin seq = 8'b010110;  len = 6; end
      14: begin seq = 8'b1010110; len = 7; end
      15: begin seq = 8'b110110;  len = 6; end
      default: begin seq = 8'b0;  len = 0; end
    endcase
    for (int i = 0; i < len; i++) step(seq[i]);
    chk(int'(st) == s, "R2 reach state", int'(st), s);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    n_chk = 0;
    n_fail = 0;
    trst_n = 1'b0;
    tms = 1'b0;
    model = 0;
    repeat (3) @(negedge tck);
    #1;
    // R1: held in reset, even with tms low
    chk(st == 4'd0, "R1 state in reset", int'(st), 0);
    chk(rst_o == 1'b1, "R1 reset_o", int'(rst_o), 1);
    chk({cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr, oe} == 7'd0, "R1 outputs low",
        int'({cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr, oe}), 0);

    // R8: release with tms low, two edges held, third moves
    trst_n = 1'b1;
    tms = 1'b0;
    @(posedge tck); #1;
    chk(st == 4'd0, "R8 first edge held", int'(st), 0);
    @(posedge tck); #1;
    chk(st == 4'd0, "R8 second edge held", int'(st), 0);
    @(posedge tck); #1;
    chk(st == 4'd1, "R8 third edge moves", int'(st), 1);
    model = 1;
    @(negedge tck); #1;

    // R2 exhaustive transitions, R4 from every state
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        goto_state(s);
        step(logic'(b));
      end
      goto_state(s);
      for (int k = 0; k < 5; k++) step(1'b1);
      chk(st == 4'd0, "R4 five ones to reset", int'(st), 0);
    end

    // R5 pause hold
    goto_state(6);
    for (int k = 0; k < 4; k++) step(1'b0);
    chk(st == 4'd6, "R5 pause-DR hold", int'(st), 6);
    goto_state(13);
    for (int k = 0; k < 4; k++) step(1'b0);
    chk(st == 4'd13, "R5 pause-IR hold", int'(st), 13);

    // R6 exits into update, R3 select-IR entry
    goto_state(7); step(1'b1);
    chk(st == 4'd8, "R6 exit2-DR to update", int'(st), 8);
    goto_state(12); step(1'b1);
    chk(st == 4'd15, "R6 exit1-IR to update", int'(st), 15);
    goto_state(15); step(1'b1); step(1'b1);
    chk(st == 4'd9, "R3 select-IR via select-DR", int'(st), 9);

    // mixed walk, biased by lfsr taps
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3]);
    end

    // R7 async reset in the middle of a shift
    goto_state(4);
    step(1'b0);
    #1;
    trst_n = 1'b0;
    #1;
    chk(st == 4'd0, "R7 async state clear", int'(st), 0);
    chk(oe == 1'b0, "R7 async tdo_oe clear", int'(oe), 0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    model = 0;
    for (int k = 0; k < 3; k++) step(1'b1);
    step(1'b0);
    chk(st == 4'd1, "R8 run after release", int'(st), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule